// File: doc/BRIEF.md
# Circular Pass-Window Locator

The locator searches a 64-entry pass/fail map, one entry per delay tap, for the contiguous run of passing taps that surrounds a requested right marker. The map is treated as a ring, so a passing run that crosses from tap 63 to tap 0 is reported as one interval. In that case its right end is given as a position beyond 63 (tap number plus one period). A calibration sequencer fills the map, either all at once from a parallel input or one tap at a time through a write port. It then pulses `start` with a range (left end, right end) and two markers. It waits for `done` and reads the interval ends, the two signed distances of those ends from the markers, and an error code.

The search is sequential and touches one map entry per cycle. It walks through named states. `ST_IDLE` takes `start` into `ST_CHECK`. `ST_CHECK` validates the parameters and goes either to `ST_IDLE` (bad parameters) or to `ST_COUNT`. `ST_COUNT` tallies passes over the range and goes to `ST_IDLE` on no-pass or all-pass, otherwise to `ST_MOD`. `ST_MOD` reduces the right marker to a map index by repeated subtraction of the range size, then branches to `ST_SCAN_UP` if that entry passes or to `ST_SCAN_PASS` if it fails. `ST_SCAN_UP` walks right until a fail and then enters `ST_SCAN_FAIL`. `ST_SCAN_PASS` walks left until a pass and then enters `ST_SCAN_FAIL`. `ST_SCAN_FAIL` walks left from the interval's right end until a fail and then returns to `ST_IDLE`. Any scan that runs past its limit returns to `ST_IDLE` with a limit error.

Top module: `pwin_locator`

## Requirements
- R1: After reset `busy`, `done` and `err_code` are 0, and `win_lo` and `win_hi` are 0.
- R2: A map bit of 1 means fail and 0 means pass. `load_all` copies `vec_in` into the whole map. `wr_en` writes `wr_fail` into the entry at `wr_addr`. When both are high in the same cycle, `load_all` wins.
- R3: While `busy` is high, `load_all` and `wr_en` are ignored, and the map keeps its contents for the running and the following searches.
- R4: The parameters are rejected with error code 1 unless all of these hold. Size is hi_end − lo_end + 1. lo_end < hi_end. hi_end ≤ 63. lo_mark is in [lo_end, hi_end]. hi_mark is in [lo_mark, hi_end + size].
- R5: If every entry from lo_end to hi_end fails, the search ends with error code 2.
- R6: If every entry from lo_end to hi_end passes, the search ends with error code 4 and reports `win_lo` = lo_end and `win_hi` = hi_end.
- R7: If the entry at hi_mark passes, the unit scans upward for a fail. The limit is hi_end + size when hi_mark > hi_end, and hi_mark + size − 1 otherwise. The interval's right end is the fail position minus 1. Passing the limit gives error code 3.
- R8: If the entry at hi_mark fails, the unit scans downward for a pass. The limit is hi_mark − size + 1 when hi_mark > hi_end, and lo_end otherwise. The interval's right end is the pass position. Passing the limit gives error code 3.
- R9: From the right end the unit scans downward for a fail. The limit is right end − size + 1 when the right end exceeds hi_end, and lo_end otherwise. `win_lo` is the fail position plus 1. Passing the limit gives error code 3. On success, error code 0 is reported unless the interval equals [lo_end, hi_end], which gives code 4.
- R10: Every scan reads the map entry at the position modulo size.
- R11: With error code 0 or 4, `diff_hi` = win_hi − hi_mark and `diff_lo` = lo_mark − win_lo, each a 9-bit two's-complement value.
- R12: `start` in idle launches a search and raises `busy` in the next cycle. `start` while busy is ignored. `done` is a one-cycle pulse in the cycle `busy` falls. Results and error code hold until the next search ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vec_in | input | 64 | Parallel map image, bit i = tap i, 1 = fail |
| load_all | input | 1 | Load the whole map from `vec_in` |
| wr_en | input | 1 | Write one map entry |
| wr_addr | input | 6 | Tap written by `wr_en` |
| wr_fail | input | 1 | Value written, 1 = fail |
| start | input | 1 | Launch a search |
| lo_end | input | 8 | Left end of the range |
| hi_end | input | 8 | Right end of the range |
| lo_mark | input | 8 | Left marker, low limit for `diff_lo` |
| hi_mark | input | 8 | Right marker, high limit for `diff_hi` |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle end-of-search pulse |
| err_code | output | 3 | 0 ok, 1 parameters, 2 no pass, 3 limit, 4 no fail |
| win_lo | output | 8 | Left end of the pass interval |
| win_hi | output | 8 | Right end of the pass interval, may exceed 63 |
| diff_hi | output | 9 | win_hi − hi_mark, signed |
| diff_lo | output | 9 | lo_mark − win_lo, signed |

## Verification
Only `busy` has a fixed latency: it is sampled on the falling edge right after the `start` edge. The results have none. They are due one cycle after the state that ends the search, and that takes 1 check cycle plus size counting cycles plus the marker reduction and scan steps. That total depends on the map, so the bench polls `done` on every falling edge and compares all results in the cycle it is seen. It checks the following falling edge for the end of the pulse, and later cycles for held results. Expected values come from an arithmetic model of the scan rules, run over wrap-around windows at many offsets and widths, random maps, a reduced range that exercises the modulo indexing, and every parameter-rejection boundary.

// File: rtl/pwl_pkg.sv
package pwl_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_COUNT,
        ST_MOD,
        ST_SCAN_UP,
        ST_SCAN_PASS,
        ST_SCAN_FAIL
    } pwl_state_e;

    localparam logic [2:0] ERR_NONE   = 3'd0;
    localparam logic [2:0] ERR_PARAM  = 3'd1;
    localparam logic [2:0] ERR_NOPASS = 3'd2;
    localparam logic [2:0] ERR_LIMIT  = 3'd3;
    localparam logic [2:0] ERR_NOFAIL = 3'd4;
endpackage

// File: rtl/pwl_vecstore.sv
module pwl_vecstore #(
    parameter int NTAP = 64,
    parameter int AW   = $clog2(NTAP)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            lock,
    input  logic            load_all,
    input  logic [NTAP-1:0] vec_in,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_addr,
    input  logic            wr_fail,
    input  logic [AW-1:0]   rd_addr,
    output logic            rd_fail
);
    logic [NTAP-1:0] mem;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem <= '0;
        end else if (!lock) begin
            if (load_all) begin
                mem <= vec_in;
            end else if (wr_en) begin
                mem[wr_addr] <= wr_fail;
            end
        end
    end

    assign rd_fail = mem[rd_addr];

    AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        lock |=> $stable(mem)); // R3
    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!lock && !load_all && wr_en) |=> (mem[$past(wr_addr)] == $past(wr_fail))); // R2
endmodule

// File: rtl/pwl_search.sv
module pwl_search
    import pwl_pkg::*;
#(
    parameter int NTAP = 64,
    parameter int PW   = 8,
    parameter int DW   = 9,
    parameter int AW   = $clog2(NTAP)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [PW-1:0] lo_end,
    input  logic [PW-1:0] hi_end,
    input  logic [PW-1:0] lo_mark,
    input  logic [PW-1:0] hi_mark,
    input  logic          rd_fail,
    output logic [AW-1:0] rd_addr,
    output logic          busy,
    output logic          done,
    output logic [2:0]    err_code,
    output logic [PW-1:0] win_lo,
    output logic [PW-1:0] win_hi,
    output logic [DW-1:0] diff_hi,
    output logic [DW-1:0] diff_lo
);
    localparam int IW = PW + 2;
    localparam logic signed [IW-1:0] ONE     = IW'(1);
    localparam logic signed [IW-1:0] LASTTAP = IW'(NTAP - 1);

    pwl_state_e st, st_nx;

    logic signed [IW-1:0] e_l, e_r, m_l, m_r;
    logic signed [IW-1:0] cur, idx, lmt, pr, pcnt;
    logic signed [IW-1:0] sz, pcnt_nx, idx_up, idx_dn;
    logic signed [IW-1:0] lmt_up, lmt_dn_cur, lmt_dn_prev;
    logic signed [IW-1:0] fin_lo, fin_hi, dh, dl;
    logic                 bad, over, under, fin, fin_res;
    logic [2:0]           fin_err;

    assign sz          = e_r - e_l + ONE;
    assign pcnt_nx     = rd_fail ? pcnt : pcnt + ONE;
    assign idx_up      = (idx == sz - ONE) ? '0 : idx + ONE;
    assign idx_dn      = (idx == '0) ? sz - ONE : idx - ONE;
    assign lmt_up      = (m_r > e_r) ? e_r + sz : m_r + sz - ONE;
    assign lmt_dn_cur  = (cur > e_r) ? cur - sz + ONE : e_l;
    assign lmt_dn_prev = ((cur - ONE) > e_r) ? cur - sz : e_l;
    assign over        = cur > lmt;
    assign under       = cur < lmt;
    assign bad         = !(e_l < e_r) || (e_r > LASTTAP) || (m_l < e_l) ||
                         (m_l > e_r) || (m_r < m_l) || (m_r > e_r + sz);
    assign busy        = (st != ST_IDLE);
    assign rd_addr     = (st == ST_COUNT) ? cur[AW-1:0] : idx[AW-1:0];
    assign dh          = fin_hi - m_r;
    assign dl          = m_l - fin_lo;

    // ending conditions of a search
    always_comb begin
        fin     = 1'b0;
        fin_res = 1'b0;
        fin_err = ERR_NONE;
        fin_lo  = cur + ONE;
        fin_hi  = pr;
        unique case (st)
            ST_CHECK: if (bad) begin
                fin = 1'b1; fin_err = ERR_PARAM;
            end
            ST_COUNT: if (cur == e_r) begin
                if (pcnt_nx == '0) begin
                    fin = 1'b1; fin_err = ERR_NOPASS;
                end else if (pcnt_nx == sz) begin
                    fin = 1'b1; fin_res = 1'b1; fin_err = ERR_NOFAIL;
                    fin_lo = e_l; fin_hi = e_r;
                end
            end
            ST_SCAN_UP: if (over) begin
                fin = 1'b1; fin_err = ERR_LIMIT;
            end
            ST_SCAN_PASS: if (under) begin
                fin = 1'b1; fin_err = ERR_LIMIT;
            end
            ST_SCAN_FAIL: if (under) begin
                fin = 1'b1; fin_err = ERR_LIMIT;
            end else if (rd_fail) begin
                fin = 1'b1; fin_res = 1'b1;
                fin_err = ((cur + ONE == e_l) && (pr == e_r)) ? ERR_NOFAIL : ERR_NONE;
            end
            default: ;
        endcase
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE:      if (start) st_nx = ST_CHECK;
            ST_CHECK:     st_nx = bad ? ST_IDLE : ST_COUNT;
            ST_COUNT:     if (fin) st_nx = ST_IDLE;
                          else if (cur == e_r) st_nx = ST_MOD;
            ST_MOD:       if (idx < sz) st_nx = rd_fail ? ST_SCAN_PASS : ST_SCAN_UP;
            ST_SCAN_UP:   if (fin) st_nx = ST_IDLE;
                          else if (rd_fail) st_nx = ST_SCAN_FAIL;
            ST_SCAN_PASS: if (fin) st_nx = ST_IDLE;
                          else if (!rd_fail) st_nx = ST_SCAN_FAIL;
            ST_SCAN_FAIL: if (fin) st_nx = ST_IDLE;
            default:      st_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            e_l <= '0; e_r <= '0; m_l <= '0; m_r <= '0;
            cur <= '0; idx <= '0; lmt <= '0; pr <= '0; pcnt <= '0;
            done <= 1'b0; err_code <= ERR_NONE;
            win_lo <= '0; win_hi <= '0; diff_hi <= '0; diff_lo <= '0;
        end else begin
            done <= fin;
            if (fin) begin
                err_code <= fin_err;
                if (fin_res) begin
                    win_lo  <= fin_lo[PW-1:0];
                    win_hi  <= fin_hi[PW-1:0];
                    diff_hi <= dh[DW-1:0];
                    diff_lo <= dl[DW-1:0];
                end
            end
            unique case (st)
                ST_IDLE: if (start) begin
                    e_l <= $signed({2'b00, lo_end});
                    e_r <= $signed({2'b00, hi_end});
                    m_l <= $signed({2'b00, lo_mark});
                    m_r <= $signed({2'b00, hi_mark});
                end
                ST_CHECK: begin
                    cur  <= e_l;
                    pcnt <= '0;
                end
                ST_COUNT: begin
                    pcnt <= pcnt_nx;
                    if (cur == e_r) begin
                        cur <= m_r;
                        idx <= m_r;
                    end else begin
                        cur <= cur + ONE;
                    end
                end
                ST_MOD: begin
                    if (idx >= sz) idx <= idx - sz;
                    else           lmt <= rd_fail ? lmt_dn_cur : lmt_up;
                end
                ST_SCAN_UP: if (!over) begin
                    if (rd_fail) begin
                        pr  <= cur - ONE;
                        cur <= cur - ONE;
                        idx <= idx_dn;
                        lmt <= lmt_dn_prev;
                    end else begin
                        cur <= cur + ONE;
                        idx <= idx_up;
                    end
                end
                ST_SCAN_PASS: if (!under) begin
                    if (!rd_fail) begin
                        pr  <= cur;
                        lmt <= lmt_dn_cur;
                    end else begin
                        cur <= cur - ONE;
                        idx <= idx_dn;
                    end
                end
                ST_SCAN_FAIL: if (!under && !rd_fail) begin
                    cur <= cur - ONE;
                    idx <= idx_dn;
                end
                default: ;
            endcase
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R12
    AST_BUSY_ENDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done); // R12
    AST_ERR_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (err_code <= ERR_NOFAIL)); // R12
    AST_WIN_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err_code == ERR_NONE) |-> (win_hi >= win_lo)); // R9
    AST_SCAN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SCAN_UP) |-> (cur <= lmt + ONE)); // R7
endmodule

// File: rtl/pwin_locator.sv
module pwin_locator
    import pwl_pkg::*;
#(
    parameter int NTAP = 64,
    parameter int PW   = 8,
    parameter int DW   = 9,
    parameter int AW   = $clog2(NTAP)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NTAP-1:0] vec_in,
    input  logic            load_all,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_addr,
    input  logic            wr_fail,
    input  logic            start,
    input  logic [PW-1:0]   lo_end,
    input  logic [PW-1:0]   hi_end,
    input  logic [PW-1:0]   lo_mark,
    input  logic [PW-1:0]   hi_mark,
    output logic            busy,
    output logic            done,
    output logic [2:0]      err_code,
    output logic [PW-1:0]   win_lo,
    output logic [PW-1:0]   win_hi,
    output logic [DW-1:0]   diff_hi,
    output logic [DW-1:0]   diff_lo
);
    logic [AW-1:0] rd_addr;
    logic          rd_fail;

    pwl_vecstore #(.NTAP(NTAP), .AW(AW)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .lock     (busy),
        .load_all (load_all),
        .vec_in   (vec_in),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_fail  (wr_fail),
        .rd_addr  (rd_addr),
        .rd_fail  (rd_fail)
    );

    pwl_search #(.NTAP(NTAP), .PW(PW), .DW(DW), .AW(AW)) u_search (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .lo_end   (lo_end),
        .hi_end   (hi_end),
        .lo_mark  (lo_mark),
        .hi_mark  (hi_mark),
        .rd_fail  (rd_fail),
        .rd_addr  (rd_addr),
        .busy     (busy),
        .done     (done),
        .err_code (err_code),
        .win_lo   (win_lo),
        .win_hi   (win_hi),
        .diff_hi  (diff_hi),
        .diff_lo  (diff_lo)
    );
endmodule

// File: tb/sim_pwin_locator.sv
`timescale 1ns/1ps
module sim_pwin_locator;
    localparam int NTAP = 64;
    localparam int PW   = 8;
    localparam int DW   = 9;
    localparam int AW   = 6;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NTAP-1:0] vec_in = '0;
    logic            load_all = 1'b0;
    logic            wr_en = 1'b0;
    logic [AW-1:0]   wr_addr = '0;
    logic            wr_fail = 1'b0;
    logic            start = 1'b0;
    logic [PW-1:0]   lo_end = '0, hi_end = '0, lo_mark = '0, hi_mark = '0;
    logic            busy, done;
    logic [2:0]      err_code;
    logic [PW-1:0]   win_lo, win_hi;
    logic [DW-1:0]   diff_hi, diff_lo;

    int nchk = 0;
    int nfail = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    pwin_locator #(.NTAP(NTAP), .PW(PW), .DW(DW), .AW(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .vec_in(vec_in), .load_all(load_all),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_fail(wr_fail), .start(start),
        .lo_end(lo_end), .hi_end(hi_end), .lo_mark(lo_mark), .hi_mark(hi_mark),
        .busy(busy), .done(done), .err_code(err_code), .win_lo(win_lo),
        .win_hi(win_hi), .diff_hi(diff_hi), .diff_lo(diff_lo)
    );

    task automatic wrap_up();
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            nfail++;
            $display("FAIL watchdog: actual hung expected finished");
            wrap_up();
        end
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // arithmetic model of the scan rules (bit 1 = fail)
    task automatic model(input logic [63:0] v, input int le, input int re,
                         input int lm, input int rm,
                         output int er, output int pl, output int pr);
        int sz, pc, c, lmt, prr;
        sz = re - le + 1;
        pl = 0; pr = 0;
        if (!(le < re) || re > 63 || lm < le || lm > re || rm < lm || rm > re + sz) begin
            er = 1; return;
        end
        pc = 0;
        for (int k = le; k <= re; k++) if (!v[k]) pc++;
        if (pc == 0) begin er = 2; return; end
        if (pc == sz) begin er = 4; pl = le; pr = re; return; end
        c = rm;
        if (!v[c % sz]) begin
            lmt = (rm > re) ? re + sz : rm + sz - 1;
            while (c <= lmt && !v[c % sz]) c++;
            if (c > lmt) begin er = 3; return; end
            prr = c - 1;
        end else begin
            lmt = (rm > re) ? rm - sz + 1 : le;
            while (c >= lmt && v[c % sz]) c--;
            if (c < lmt) begin er = 3; return; end
            prr = c;
        end
        c = prr;
        lmt = (prr > re) ? prr - sz + 1 : le;
        while (c >= lmt && !v[c % sz]) c--;
        if (c < lmt) begin er = 3; return; end
        pl = c + 1; pr = prr;
        er = (pl == le && pr == re) ? 4 : 0;
    endtask

    task automatic load_vec(input logic [63:0] v, input bit viaport);
        if (viaport) begin
            for (int k = 0; k < NTAP; k++) begin
                @(negedge clk);
                wr_en = 1'b1; wr_addr = AW'(k); wr_fail = v[k];
            end
            @(negedge clk);
            wr_en = 1'b0;
        end else begin
            @(negedge clk);
            load_all = 1'b1; vec_in = v;
            @(negedge clk);
            load_all = 1'b0;
        end
    endtask

    task automatic launch(input int le, input int re, input int lm, input int rm);
        @(negedge clk);
        lo_end = PW'(le); hi_end = PW'(re); lo_mark = PW'(lm); hi_mark = PW'(rm);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R12", "busy after start", int'(busy), 1);
    endtask

    task automatic wait_done();
        bit seen;
        seen = 1'b0;
        for (int k = 0; k < 3000 && !seen; k++) begin
            if (k != 0) @(negedge clk);
            if (done) seen = 1'b1;
        end
        chk(seen, "R12", "done seen", int'(seen), 1);
    endtask

    task automatic compare(input logic [63:0] v, input int le, input int re,
                           input int lm, input int rm, input string tag);
        int er, pl, pr;
        model(v, le, re, lm, rm, er, pl, pr);
        chk(int'(err_code) == er, tag, "err_code", int'(err_code), er);
        if (er == 0 || er == 4) begin
            chk(int'(win_lo) == pl, "R9", "win_lo", int'(win_lo), pl);
            chk(int'(win_hi) == pr, "R9", "win_hi", int'(win_hi), pr);
            chk(int'($signed(diff_hi)) == pr - rm, "R11", "diff_hi", int'($signed(diff_hi)), pr - rm);
            chk(int'($signed(diff_lo)) == lm - pl, "R11", "diff_lo", int'($signed(diff_lo)), lm - pl);
        end
    endtask

    task automatic search(input logic [63:0] v, input int le, input int re,
                          input int lm, input int rm, input string tag);
        launch(le, re, lm, rm);
        @(negedge clk);
        wait_done();
        compare(v, le, re, lm, rm, tag);
        @(negedge clk);
        chk(done == 1'b0, "R12", "done pulse width", int'(done), 0);
    endtask

    task automatic run(input logic [63:0] v, input int le, input int re,
                       input int lm, input int rm, input bit viaport, input string tag);
        load_vec(v, viaport);
        search(v, le, re, lm, rm, tag);
    endtask

    function automatic logic [63:0] mkwin(input int s, input int len);
        logic [63:0] v;
        v = '1;
        for (int k = 0; k < len; k++) v[(s + k) % 64] = 1'b0;
        return v;
    endfunction

    initial begin
        logic [63:0] v0, rv;
        int lens[5];
        int hold_hi, hold_err;
        lens = '{1, 4, 17, 40, 63};

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(busy == 1'b0, "R1", "busy", int'(busy), 0);
        chk(done == 1'b0, "R1", "done", int'(done), 0);
        chk(err_code == 3'd0, "R1", "err_code", int'(err_code), 0);
        chk(win_lo == '0 && win_hi == '0, "R1", "window", int'(win_hi), 0);

        // R4 parameter checks and boundaries
        v0 = mkwin(10, 20);
        run(v0, 5, 5, 5, 5, 1'b0, "R4");
        search(v0, 0, 64, 0, 10, "R4");
        search(v0, 3, 10, 2, 5, "R4");
        search(v0, 3, 10, 11, 11, "R4");
        search(v0, 0, 63, 20, 19, "R4");
        search(v0, 0, 63, 0, 128, "R4");
        search(v0, 0, 63, 12, 127, "R4");
        search(v0, 0, 63, 63, 63, "R4");

        // R5 all fail, R6 all pass
        run('1, 0, 63, 5, 40, 1'b0, "R5");
        run('0, 0, 63, 5, 40, 1'b0, "R6");
        run('0, 0, 63, 0, 127, 1'b1, "R6");

        // R7 scan-limit error: only tap 2 fails, marker beyond the end
        v0 = '0; v0[2] = 1'b1;
        run(v0, 0, 63, 0, 100, 1'b0, "R7");

        // R7 / R8 sweep of wrapping windows
        for (int s = 0; s < 64; s += 5) begin
            for (int li = 0; li < 5; li++) begin
                v0 = mkwin(s, lens[li]);
                run(v0, 0, 63, s, s + lens[li] / 2, (s % 10) == 0, "R7");
                search(v0, 0, 63, s, s + lens[li] + 1, "R8");
                search(v0, 0, 63, s, s, "R7");
            end
        end

        // R10 reduced range exercising modulo indexing
        v0 = 64'h0;
        v0[1] = 1'b1; v0[6] = 1'b1; v0[8] = 1'b1;
        load_vec(v0, 1'b0);
        for (int rm = 2; rm <= 17; rm++) search(v0, 2, 9, 2, rm, "R10");
        for (int rm = 5; rm <= 17; rm += 3) search(v0, 2, 9, 5, rm, "R10");
        v0 = 64'hFFFF_FFFF_FFFF_FF3C;
        load_vec(v0, 1'b0);
        for (int rm = 0; rm <= 15; rm++) search(v0, 0, 7, 0, rm, "R10");

        // random maps with valid markers
        rv = 64'h9E37_79B9_7F4A_7C15;
        for (int n = 0; n < 80; n++) begin
            int lm, rm;
            rv = rv ^ (rv << 13); rv = rv ^ (rv >> 7); rv = rv ^ (rv << 17);
            lm = int'(rv[5:0]);
            rm = lm + int'(rv[21:14]) % (128 - lm);
            v0 = rv & {rv[31:0], rv[63:32]};
            run(v0, 0, 63, lm, rm, 1'b0, "R8");
        end

        // R2 load_all wins over a conflicting single write
        v0 = mkwin(50, 30);
        @(negedge clk);
        load_all = 1'b1; vec_in = v0; wr_en = 1'b1; wr_addr = 6'd55; wr_fail = 1'b1;
        @(negedge clk);
        load_all = 1'b0; wr_en = 1'b0;
        search(v0, 0, 63, 55, 60, "R2");

        // R3 loads during a search are ignored
        v0 = mkwin(20, 9);
        load_vec(v0, 1'b0);
        launch(0, 63, 20, 24);
        for (int k = 0; k < 4; k++) begin
            load_all = 1'b1; vec_in = '1; wr_en = 1'b1; wr_addr = AW'(20 + k); wr_fail = 1'b1;
            @(negedge clk);
        end
        load_all = 1'b0; wr_en = 1'b0;
        wait_done();
        compare(v0, 0, 63, 20, 24, "R3");
        search(v0, 0, 63, 20, 24, "R3");

        // R12 start while busy ignored, results held
        v0 = mkwin(60, 12);
        load_vec(v0, 1'b0);
        launch(0, 63, 60, 66);
        repeat (3) @(negedge clk);
        lo_end = 8'd5; hi_end = 8'd5; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done();
        compare(v0, 0, 63, 60, 66, "R12");
        hold_hi = int'(win_hi); hold_err = int'(err_code);
        repeat (5) @(negedge clk);
        chk(int'(win_hi) == hold_hi && int'(err_code) == hold_err && !done && !busy,
            "R12", "held result", int'(win_hi), hold_hi);

        finished = 1'b1;
        wrap_up();
    end
endmodule